// File: doc/BRIEF.md
# Memory Card Bus Clock Gater

This block sits on the host side of a memory-card bus and decides when the bus clock may be stopped. It follows each bus transaction through its end events: the end bit of a host command, the end bit of the card's response, and the end bit of the last block of read data. When the command is issued, two flags say whether a response and whether read data are to follow. The block knows which end event closes the transaction. After that event it keeps the clock running for a fixed tail of eight cycles.

Host software raises a level stop request when it wants the clock off. The request takes effect only when the bus is quiet, meaning no transaction is open and the tail has run out. A command that starts during the tail cancels the pending stop. The tail then restarts from the end of that new transaction. The enable output is registered on the falling edge of the host clock, so a downstream gate never cuts a high phase short.

Top module: `mmcg_clock_gater`

## Requirements
- R1: After reset, with the stop request low, `busClkEn` is 1, `safeStop` is 1 and no tail is running.
- R2: For a command with `rspExpected`=0 and `dataExpected`=0, `safeStop` stays 0 through the seventh rising edge after the edge that samples `cmdEnd` and becomes 1 on the eighth.
- R3: For a command with `rspExpected`=1 and `dataExpected`=0, `cmdEnd` starts no tail. The eight-cycle tail is counted from the edge that samples `rspEnd`.
- R4: For a command with `dataExpected`=1, neither `cmdEnd` nor `rspEnd` starts the tail. The eight-cycle tail is counted from the edge that samples `dataEnd`.
- R5: While a transaction or its tail is in progress, `busClkEn` is 1 whatever the stop request, so the card is clocked whenever it may drive the bus.
- R6: When `stopReq` is 1 and the bus is quiet, `busClkEn` drops to 0. When `stopReq` returns to 0, it rises to 1 at the next falling clock edge.
- R7: A `cmdStart` sampled during the tail (or at any time) clears `safeStop` on the next edge. The tail is counted again from the new transaction's closing event.
- R8: `busClkEn` changes only while `clk` is low.
- R9: End strobes that do not match the current phase have no effect. This covers `rspEnd` or `dataEnd` while quiet, and `dataEnd` while a response is awaited. `safeStop` and `busClkEn` keep their values.
- R10: A `cmdStart` while the clock is gated re-enables `busClkEn` at the falling edge that follows the edge sampling it, even with `stopReq` held at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running host clock, source of the bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stopReq | input | 1 | Level request from software to stop the bus clock |
| cmdStart | input | 1 | One-cycle strobe: host begins sending a command |
| cmdEnd | input | 1 | One-cycle strobe: command end bit sent |
| rspExpected | input | 1 | With `cmdEnd`: a card response follows |
| dataExpected | input | 1 | With `cmdEnd`: read data blocks follow |
| rspEnd | input | 1 | One-cycle strobe: response end bit received |
| dataEnd | input | 1 | One-cycle strobe: end bit of last data block received |
| busClkEn | output | 1 | Bus clock enable, changes on the low phase only |
| safeStop | output | 1 | 1 when no transaction is open and the tail has elapsed |

## Verification
The main function is tried with three command shapes. The first has no response, the second has a response only, and the third has a response and read data. Each shape separates the cases where the tail is counted from the wrong end event. A command restarted during the tail shows whether the counter reloads or merely resumes. Stray end strobes while quiet or in the wrong phase show whether the phase tracking ignores them. Raising and dropping the stop request, with and without a transaction open, tells the quiet-bus gating apart from the transaction hold.

// File: rtl/mmcg_pkg.sv
package mmcg_pkg;

  typedef enum logic [2:0] {
    ST_QUIET,
    ST_CMD,
    ST_RSP,
    ST_DATA,
    ST_TAIL
  } gateState_t;

  typedef struct packed {
    logic loadTail;
    logic clrTail;
  } tailCtl_t;

endpackage

// File: rtl/mmcg_ctrl.sv
module mmcg_ctrl
  import mmcg_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     cmdStart,
  input  logic     cmdEnd,
  input  logic     rspExpected,
  input  logic     dataExpected,
  input  logic     rspEnd,
  input  logic     dataEnd,
  input  logic     tailDone,
  output tailCtl_t ctl,
  output logic     busQuiet
);

  gateState_t state, stateNext;
  logic       dataPend, dataPendNext;

  always_comb begin
    stateNext    = state;
    dataPendNext = dataPend;
    ctl          = '0;
    if (cmdStart) begin
      stateNext    = ST_CMD;
      dataPendNext = 1'b0;
      ctl.clrTail  = 1'b1;
    end else begin
      unique case (state)
        ST_CMD: begin
          if (cmdEnd) begin
            dataPendNext = dataExpected;
            if (rspExpected) begin
              stateNext = ST_RSP;
            end else if (dataExpected) begin
              stateNext = ST_DATA;
            end else begin
              stateNext    = ST_TAIL;
              ctl.loadTail = 1'b1;
            end
          end
        end
        ST_RSP: begin
          if (rspEnd) begin
            if (dataPend) begin
              stateNext = ST_DATA;
            end else begin
              stateNext    = ST_TAIL;
              ctl.loadTail = 1'b1;
            end
          end
        end
        ST_DATA: begin
          if (dataEnd) begin
            stateNext    = ST_TAIL;
            ctl.loadTail = 1'b1;
          end
        end
        ST_TAIL: begin
          if (tailDone) begin
            stateNext = ST_QUIET;
          end
        end
        default: begin
          stateNext = ST_QUIET;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_QUIET;
      dataPend <= 1'b0;
    end else begin
      state    <= stateNext;
      dataPend <= dataPendNext;
    end
  end

  assign busQuiet = (state == ST_QUIET);

endmodule

// File: rtl/mmcg_datapath.sv
module mmcg_datapath
  import mmcg_pkg::*;
#(
  parameter int TAIL_CYCLES = 8
) (
  input  logic     clk,
  input  logic     rstN,
  input  tailCtl_t ctl,
  input  logic     busQuiet,
  input  logic     stopReq,
  output logic     tailDone,
  output logic     busClkEn
);

  localparam int CNT_W = $clog2(TAIL_CYCLES + 1);

  logic [CNT_W-1:0] tailCnt;
  logic             gateReq;
  logic             enLow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tailCnt <= '0;
    end else if (ctl.clrTail) begin
      tailCnt <= '0;
    end else if (ctl.loadTail) begin
      tailCnt <= CNT_W'(TAIL_CYCLES);
    end else if (tailCnt != '0) begin
      tailCnt <= tailCnt - 1'b1;
    end
  end

  assign tailDone = (tailCnt == CNT_W'(1));

  assign gateReq = stopReq && busQuiet;

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      enLow <= 1'b1;
    end else begin
      enLow <= !gateReq;
    end
  end

  assign busClkEn = enLow;

endmodule

// File: rtl/mmcg_clock_gater.sv
module mmcg_clock_gater
  import mmcg_pkg::*;
#(
  parameter int TAIL_CYCLES = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic stopReq,
  input  logic cmdStart,
  input  logic cmdEnd,
  input  logic rspExpected,
  input  logic dataExpected,
  input  logic rspEnd,
  input  logic dataEnd,
  output logic busClkEn,
  output logic safeStop
);

  tailCtl_t ctl;
  logic     tailDone;
  logic     busQuiet;

  mmcg_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cmdStart     (cmdStart),
    .cmdEnd       (cmdEnd),
    .rspExpected  (rspExpected),
    .dataExpected (dataExpected),
    .rspEnd       (rspEnd),
    .dataEnd      (dataEnd),
    .tailDone     (tailDone),
    .ctl          (ctl),
    .busQuiet     (busQuiet)
  );

  mmcg_datapath #(
    .TAIL_CYCLES (TAIL_CYCLES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .busQuiet (busQuiet),
    .stopReq  (stopReq),
    .tailDone (tailDone),
    .busClkEn (busClkEn)
  );

  assign safeStop = busQuiet;

endmodule

// File: rtl/mmcg_checker.sv
module mmcg_checker (
  input logic clk,
  input logic rstN,
  input logic stopReq,
  input logic cmdStart,
  input logic rspEnd,
  input logic dataEnd,
  input logic busClkEn,
  input logic safeStop
);

  // R5: a busy bus is always clocked
  a_r5_busy_clocked: assert property (@(posedge clk) disable iff (!rstN)
    !safeStop |-> busClkEn);

  // R6: gating happens only on a quiet bus
  a_r6_gate_only_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busClkEn |-> safeStop);

  // R7: a new command opens a transaction on the next edge
  a_r7_cmd_reopens: assert property (@(posedge clk) disable iff (!rstN)
    cmdStart |=> !safeStop);

  // R9: stray end strobes leave a quiet bus quiet
  a_r9_stray_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (safeStop && !cmdStart && (rspEnd || dataEnd)) |=> safeStop);

  // R6: a quiet bus without a stop request runs its clock
  a_r6_no_stop_runs: assert property (@(posedge clk) disable iff (!rstN)
    (safeStop && !stopReq && $past(!stopReq)) |-> busClkEn);

  // R8: enable moves only in the low phase
  always @(busClkEn) begin
    if (rstN) begin
      a_r8_low_phase: assert (clk == 1'b0)
        else $error("enable changed while clock high");
    end
  end

endmodule

bind mmcg_clock_gater mmcg_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .stopReq  (stopReq),
  .cmdStart (cmdStart),
  .rspEnd   (rspEnd),
  .dataEnd  (dataEnd),
  .busClkEn (busClkEn),
  .safeStop (safeStop)
);

// File: tb/sim_mmcg_clock_gater.sv
`timescale 1ns/1ps
module sim_mmcg_clock_gater;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stopReq = 1'b0, cmdStart = 1'b0, cmdEnd = 1'b0;
  logic rspExpected = 1'b0, dataExpected = 1'b0, rspEnd = 1'b0, dataEnd = 1'b0;
  logic busClkEn, safeStop;

  int checks = 0;
  int failures = 0;
  string curReq = "R1";

  always #10 clk = ~clk;

  mmcg_clock_gater u0 (
    .clk(clk), .rstN(rstN), .stopReq(stopReq), .cmdStart(cmdStart),
    .cmdEnd(cmdEnd), .rspExpected(rspExpected), .dataExpected(dataExpected),
    .rspEnd(rspEnd), .dataEnd(dataEnd), .busClkEn(busClkEn), .safeStop(safeStop)
  );

  task automatic chk(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // behavioural reference: 0 quiet, 1 command, 2 await response, 3 await data, 4 tail
  int mState = 0;
  int mLeft = 0;
  bit mData = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mLeft = 0; mData = 0;
    end else begin
      if (cmdStart) begin
        mState = 1; mLeft = 0;
      end else if (mState == 1 && cmdEnd) begin
        mData = dataExpected;
        if (rspExpected) mState = 2;
        else if (dataExpected) mState = 3;
        else begin mState = 4; mLeft = 8; end
      end else if (mState == 2 && rspEnd) begin
        if (mData) mState = 3;
        else begin mState = 4; mLeft = 8; end
      end else if (mState == 3 && dataEnd) begin
        mState = 4; mLeft = 8;
      end else if (mState == 4) begin
        mLeft--;
        if (mLeft == 0) mState = 0;
      end
      #5;
      chk(curReq, safeStop, (mState == 0), "model safeStop");
      #8;
      chk(curReq, busClkEn, !(stopReq && mState == 0), "model busClkEn");
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  // 0 cmdStart, 1 cmdEnd, 2 rspEnd, 3 dataEnd
  task automatic strobe(input int which, input logic rsp, input logic dat);
    case (which)
      0: cmdStart = 1'b1;
      1: begin cmdEnd = 1'b1; rspExpected = rsp; dataExpected = dat; end
      2: rspEnd = 1'b1;
      default: dataEnd = 1'b1;
    endcase
    @(posedge clk); #2;
    cmdStart = 1'b0; cmdEnd = 1'b0; rspEnd = 1'b0; dataEnd = 1'b0;
    rspExpected = 1'b0; dataExpected = 1'b0;
  endtask

  task automatic issue(input logic rsp, input logic dat);
    strobe(0, 1'b0, 1'b0);
    idle(3);
    strobe(1, rsp, dat);
  endtask

  // called right after the strobe whose edge opens the tail
  task automatic expectTail(input string tag);
    repeat (7) @(posedge clk);
    #5 chk(tag, safeStop, 1'b0, "tail edge 7");
    @(posedge clk);
    #5 chk(tag, safeStop, 1'b1, "tail edge 8");
    @(posedge clk); #2;
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    #3;
    curReq = "R1";
    chk("R1", busClkEn, 1'b1, "reset enable");
    chk("R1", safeStop, 1'b1, "reset quiet");
    @(posedge clk); #2;

    // R2: no response
    curReq = "R2";
    stopReq = 1'b1;
    idle(2);
    issue(1'b0, 1'b0);
    expectTail("R2");
    #11 chk("R6", busClkEn, 1'b0, "gated after tail");
    @(posedge clk); #2;

    // R10: wake up from gated state
    curReq = "R10";
    strobe(0, 1'b0, 1'b0);
    #10 chk("R10", busClkEn, 1'b1, "command wakes clock");
    @(posedge clk); #2;
    idle(2);
    strobe(1, 1'b0, 1'b0);
    expectTail("R10");

    // R3: response closes
    curReq = "R3";
    issue(1'b1, 1'b0);
    idle(11);
    #3 chk("R3", safeStop, 1'b0, "no tail from command end");
    chk("R5", busClkEn, 1'b1, "clocked while awaiting response");
    @(posedge clk); #2;
    strobe(2, 1'b0, 1'b0);
    expectTail("R3");

    // R4: read data closes
    curReq = "R4";
    issue(1'b1, 1'b1);
    idle(4);
    strobe(2, 1'b0, 1'b0);
    idle(10);
    #3 chk("R4", safeStop, 1'b0, "no tail from response end");
    @(posedge clk); #2;
    strobe(3, 1'b0, 1'b0);
    expectTail("R4");

    // R4 variant: data without response
    issue(1'b0, 1'b1);
    idle(9);
    strobe(3, 1'b0, 1'b0);
    expectTail("R4");

    // R7: restart during tail
    curReq = "R7";
    issue(1'b0, 1'b0);
    idle(4);
    strobe(0, 1'b0, 1'b0);
    #3 chk("R7", safeStop, 1'b0, "restart cancels quiet");
    idle(2);
    strobe(1, 1'b0, 1'b0);
    expectTail("R7");

    // R9: stray strobes
    curReq = "R9";
    strobe(2, 1'b0, 1'b0);
    strobe(3, 1'b0, 1'b0);
    #3 chk("R9", safeStop, 1'b1, "stray strobes while quiet");
    #8 chk("R9", busClkEn, 1'b0, "still gated");
    @(posedge clk); #2;
    issue(1'b1, 1'b0);
    strobe(3, 1'b0, 1'b0);
    idle(10);
    #3 chk("R9", safeStop, 1'b0, "data end while awaiting response");
    @(posedge clk); #2;
    strobe(2, 1'b0, 1'b0);
    expectTail("R9");

    // R6: release stop
    curReq = "R6";
    stopReq = 1'b0;
    #10 chk("R6", busClkEn, 1'b1, "stop released");
    @(posedge clk); #2;
    idle(3);
    stopReq = 1'b1;
    idle(2);
    #11 chk("R6", busClkEn, 1'b0, "stop applied on quiet bus");
    @(posedge clk); #2;
    stopReq = 1'b0;
    idle(3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule